// File: doc/BRIEF.md
# Sleep-Depth Sequencer with Periodic Wake Timer

This block decides when an 8-bit microcontroller core may run, and when its clocks and oscillator may be switched off. It has two sleep depths. In deep stop the oscillator is switched off, and only a hardware reset brings the chip back. In nap the oscillator keeps running and only the CPU clock is gated. A built-in prescaler and an 8-bit compare timer can end a nap after a programmable period. An external interrupt can also end a nap, at once.

A hardware reset puts the block into a stabilization wait. During that wait the oscillator runs, while the CPU clock stays off and the internal core reset stays asserted. The wait lasts a fixed count of cycles that software cannot change. Leaving a nap needs no such wait, because the oscillator never stopped. When a nap ends without a reset, the global interrupt-enable flag is sampled in the same cycle. That sample decides whether the core takes the interrupt vector or resumes at the instruction after the sleep request.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `osc_en`=1, `cpu_clk_en`=0 and `core_rst`=1, and neither wake pulse is asserted.
- R2: After `rst_n` rises, `cpu_clk_en` rises and `core_rst` falls at exactly the STAB_CYCLES-th rising clock edge. `stab_done` pulses high for one cycle at that same edge.
- R3: A `sleep_req` taken while running with `wkt_en`=0 enters deep stop on the next edge, which drives `osc_en`=0 and `cpu_clk_en`=0.
- R4: In deep stop, `ext_irq` and the timer have no effect. The block stays stopped, with no wake pulse, until `rst_n` goes low.
- R5: A `sleep_req` taken while running with `wkt_en`=1 enters nap on the next edge, with `osc_en`=1 and `cpu_clk_en`=0.
- R6: Entering nap clears the prescaler and the timer. With `tmr_sel`=3 (the divide-by-2^DIV_LOG2 tap), the nap ends 2^DIV_LOG2 × (`tmr_period`+1) edges after the entry edge.
- R7: With any `tmr_sel` value other than 3, the timer never ends a nap.
- R8: During a nap, `ext_irq` ends the nap at the next edge. `cpu_clk_en` returns to 1 at that edge, and `core_rst` stays 0.
- R9: A nap exit raises exactly one one-cycle pulse. The pulse is `wake_vec` if `int_en` was 1 at the exit edge, and `wake_resume` otherwise.
- R10: An `ext_irq` present in the same cycle as an accepted nap request is kept. The nap lasts exactly one cycle.
- R11: `ext_irq` while running produces no wake pulse and leaves `cpu_clk_en` at 1.
- R12: A reset taken during a nap or a deep stop leads to the full R2 stabilization wait before the core runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sleep_req | input | 1 | Sleep request from the CPU, one cycle |
| wkt_en | input | 1 | 1 selects nap, 0 selects deep stop |
| tmr_sel | input | 2 | Timer clock tap; 3 is the slowest tap and the only one that wakes |
| tmr_period | input | 8 | Compare value that sets the nap length |
| ext_irq | input | 1 | External interrupt, synchronous |
| int_en | input | 1 | Global interrupt-enable flag |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_rst | output | 1 | Internal core reset, held during stabilization |
| stab_done | output | 1 | One-cycle pulse when stabilization ends |
| wake_vec | output | 1 | One-cycle pulse: take the interrupt vector |
| wake_resume | output | 1 | One-cycle pulse: resume after the sleep instruction |

## Verification
The case that is hardest to reach from the ports is a wake event that arrives in the same cycle as the sleep request. The bench drives `sleep_req` and `ext_irq` together for one cycle and then expects the clock gate to be low for exactly one sample. Timer wakes need thousands of cycles at the slow tap. The bench therefore counts edges to the exact value that the period formula gives. It also keeps a nap open on a fast tap long enough that a wrong wake from the timer would show up before the late interrupt arrives.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        LPW_STAB = 2'd0,
        LPW_RUN  = 2'd1,
        LPW_STOP = 2'd2,
        LPW_NAP  = 2'd3
    } lpw_state_e;

    localparam int unsigned LPW_NTAP = 4;

    // log2 of the divide ratio of prescaler tap i; the last tap is the full divider
    function automatic int unsigned lpw_tap_log2(int unsigned i, int unsigned div_log2);
        if (i == LPW_NTAP - 1) return div_log2;
        return 1 + i * ((div_log2 - 1) / (LPW_NTAP - 1));
    endfunction

endpackage

// File: rtl/lpw_prescaler.sv
module lpw_prescaler
    import lpw_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                run,
    output logic [LPW_NTAP-1:0] tick
);

    typedef struct packed {
        logic [DIV_LOG2-1:0] cnt;
    } pre_t;

    pre_t d, q;

    always_comb begin
        d = q;
        if (clr)      d.cnt = '0;
        else if (run) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < LPW_NTAP; g++) begin : g_tap
        localparam int unsigned TAP_L = lpw_tap_log2(g, DIV_LOG2);
        localparam logic [DIV_LOG2-1:0] TAP_M = {DIV_LOG2{1'b1}} >> (DIV_LOG2 - TAP_L);
        assign tick[g] = run && ((q.cnt & TAP_M) == TAP_M);
    end

    p_pre_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0));

endmodule

// File: rtl/lpw_wake_timer.sv
module lpw_wake_timer #(
    parameter int unsigned TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period,
    output logic             match
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;
    logic hit;

    always_comb begin
        d   = q;
        hit = 1'b0;
        if (clr) begin
            d.cnt = '0;
        end else if (en && tick) begin
            if (q.cnt == period) begin
                hit   = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    assign match = hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_tmr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0));

    p_tmr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(q.cnt));

endmodule

// File: rtl/lpw_sequencer.sv
module lpw_sequencer
    import lpw_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 256000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wkt_en,
    input  logic ext_irq,
    input  logic int_en,
    input  logic tmr_match,
    output logic nap_clr,
    output logic nap_on,
    output logic osc_en,
    output logic cpu_clk_en,
    output logic core_rst,
    output logic stab_done,
    output logic wake_vec,
    output logic wake_resume
);

    localparam int unsigned STAB_W = $clog2(STAB_CYCLES + 1);
    localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(STAB_CYCLES - 1);

    typedef struct packed {
        lpw_state_e        state;
        logic [STAB_W-1:0] stab_cnt;
        logic              pend;
        logic              vec;
        logic              res;
        logic              sdone;
    } seq_t;

    seq_t d, q;
    logic clr_c;

    always_comb begin
        d       = q;
        d.vec   = 1'b0;
        d.res   = 1'b0;
        d.sdone = 1'b0;
        clr_c   = 1'b0;
        unique case (q.state)
            LPW_STAB: begin
                if (q.stab_cnt == STAB_LAST) begin
                    d.state    = LPW_RUN;
                    d.sdone    = 1'b1;
                    d.stab_cnt = '0;
                end else begin
                    d.stab_cnt = q.stab_cnt + 1'b1;
                end
            end
            LPW_RUN: begin
                if (sleep_req) begin
                    if (wkt_en) begin
                        d.state = LPW_NAP;
                        d.pend  = ext_irq;
                        clr_c   = 1'b1;
                    end else begin
                        d.state = LPW_STOP;
                    end
                end
            end
            LPW_NAP: begin
                if (ext_irq || q.pend || tmr_match) begin
                    d.state = LPW_RUN;
                    d.pend  = 1'b0;
                    d.vec   = int_en;
                    d.res   = !int_en;
                end
            end
            default: begin
                d.state = LPW_STOP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= LPW_STAB;
        end else begin
            q <= d;
        end
    end

    assign nap_clr     = clr_c;
    assign nap_on      = (q.state == LPW_NAP);
    assign osc_en      = (q.state != LPW_STOP);
    assign cpu_clk_en  = (q.state == LPW_RUN);
    assign core_rst    = (q.state == LPW_STAB);
    assign stab_done   = q.sdone;
    assign wake_vec    = q.vec;
    assign wake_resume = q.res;

    p_hold_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (!cpu_clk_en && osc_en && !wake_vec && !wake_resume));

    p_stab_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stab_done |-> ($past(core_rst) && !core_rst && cpu_clk_en));

    p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_req && !wkt_en) |=> (!osc_en && !cpu_clk_en));

    p_stop_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> (!osc_en && !wake_vec && !wake_resume));

    p_nap_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_req && wkt_en) |=> (osc_en && !cpu_clk_en && nap_on));

    p_nap_irq_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nap_on && ext_irq) |=> (cpu_clk_en && !core_rst));

    p_vec_follows_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_vec |-> ($past(int_en) && !wake_resume));

    p_resume_follows_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_resume |-> !$past(int_en));

    p_same_cycle_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_req && wkt_en && ext_irq) |=> ##1 cpu_clk_en);

    p_run_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !sleep_req && ext_irq) |=> (cpu_clk_en && !wake_vec && !wake_resume));

endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int unsigned DIV_LOG2    = 11,
    parameter int unsigned TMR_W       = 8,
    parameter int unsigned STAB_CYCLES = 256000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wkt_en,
    input  logic [1:0]       tmr_sel,
    input  logic [TMR_W-1:0] tmr_period,
    input  logic             ext_irq,
    input  logic             int_en,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             core_rst,
    output logic             stab_done,
    output logic             wake_vec,
    output logic             wake_resume
);

    localparam logic [1:0] LONG_SEL = 2'(LPW_NTAP - 1);

    logic [LPW_NTAP-1:0] ticks;
    logic                nap_clr;
    logic                nap_on;
    logic                tmr_en;
    logic                tmr_match;

    assign tmr_en = nap_on && (tmr_sel == LONG_SEL);

    lpw_prescaler #(.DIV_LOG2(DIV_LOG2)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (nap_clr),
        .run  (nap_on),
        .tick (ticks)
    );

    lpw_wake_timer #(.TMR_W(TMR_W)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nap_clr),
        .en    (tmr_en),
        .tick  (ticks[tmr_sel]),
        .period(tmr_period),
        .match (tmr_match)
    );

    lpw_sequencer #(.STAB_CYCLES(STAB_CYCLES)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wkt_en     (wkt_en),
        .ext_irq    (ext_irq),
        .int_en     (int_en),
        .tmr_match  (tmr_match),
        .nap_clr    (nap_clr),
        .nap_on     (nap_on),
        .osc_en     (osc_en),
        .cpu_clk_en (cpu_clk_en),
        .core_rst   (core_rst),
        .stab_done  (stab_done),
        .wake_vec   (wake_vec),
        .wake_resume(wake_resume)
    );

    p_slow_tap_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_match |-> (tmr_sel == LONG_SEL));

endmodule

// File: tb/test_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module test_lpm_wake_ctrl;

    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wkt_en = 1'b0;
    logic [1:0] tmr_sel = 2'd3;
    logic [7:0] tmr_period = 8'd0;
    logic       ext_irq = 1'b0;
    logic       int_en = 1'b0;
    logic osc_en, cpu_clk_en, core_rst, stab_done, wake_vec, wake_resume;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lpm_wake_ctrl #(.STAB_CYCLES(STAB)) i_lpm_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wkt_en(wkt_en),
        .tmr_sel(tmr_sel), .tmr_period(tmr_period), .ext_irq(ext_irq), .int_en(int_en),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .core_rst(core_rst),
        .stab_done(stab_done), .wake_vec(wake_vec), .wake_resume(wake_resume)
    );

    typedef struct packed {
        logic        wkt;
        logic [1:0]  sel;
        logic [7:0]  per;
        logic        ie;
        logic        same;
        logic [15:0] irq_at;
        logic [15:0] exp_n;
    } vec_t;

    // timer wakes R6, fast tap R7, external wake R8, same-cycle event R10
    localparam vec_t TBL [6] = '{
        '{1'b1, 2'd3, 8'd0, 1'b1, 1'b0, 16'd0,   16'd2049},
        '{1'b1, 2'd3, 8'd2, 1'b0, 1'b0, 16'd0,   16'd6145},
        '{1'b1, 2'd0, 8'd0, 1'b1, 1'b0, 16'd3000, 16'd3001},
        '{1'b1, 2'd3, 8'd5, 1'b0, 1'b0, 16'd10,  16'd11},
        '{1'b1, 2'd3, 8'd0, 1'b1, 1'b1, 16'd0,   16'd2},
        '{1'b1, 2'd2, 8'd1, 1'b0, 1'b0, 16'd500, 16'd501}
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // counts rising edges until cpu_clk_en is seen high; optional irq pulse at edge count irq_at
    task automatic count_to_run(input int irq_at, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            ext_irq = (irq_at != 0 && n == irq_at);
            @(posedge clk);
            @(negedge clk);
            sleep_req = 1'b0;
            n++;
            if (cpu_clk_en) break;
        end
        ext_irq = 1'b0;
    endtask

    task automatic stab_check(input string req);
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        count_to_run(0, 1000, n);
        chk(n == STAB, req, "edges to run after reset", n, STAB);
        chk(stab_done == 1'b1 && core_rst == 1'b0, req, "stab_done at release", stab_done, 1);
        @(negedge clk);
        chk(stab_done == 1'b0, req, "stab_done one cycle", stab_done, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(osc_en && !cpu_clk_en && core_rst && !wake_vec && !wake_resume,
            "R1", "outputs in reset", {osc_en, cpu_clk_en, core_rst}, 3'b101);
        // R2 stabilization count
        stab_check("R2");

        // R11 ext_irq while running
        ext_irq = 1'b1;
        @(posedge clk); @(negedge clk);
        ext_irq = 1'b0;
        chk(!wake_vec && !wake_resume && cpu_clk_en, "R11", "no wake pulse in run",
            {wake_vec, wake_resume, cpu_clk_en}, 3'b001);

        // table of nap cases
        for (int i = 0; i < 6; i++) begin
            wkt_en = TBL[i].wkt;
            tmr_sel = TBL[i].sel;
            tmr_period = TBL[i].per;
            int_en = TBL[i].ie;
            sleep_req = 1'b1;
            ext_irq = TBL[i].same;
            @(posedge clk); @(negedge clk);
            sleep_req = 1'b0;
            ext_irq = 1'b0;
            chk(osc_en && !cpu_clk_en, "R5", $sformatf("nap entry row %0d", i),
                {osc_en, cpu_clk_en}, 2'b10);
            if (TBL[i].same) begin
                @(posedge clk); @(negedge clk);
                n = 2;
            end else begin
                count_to_run(int'(TBL[i].irq_at) == 0 ? 0 : int'(TBL[i].irq_at) - 1, 20000, n);
                n = n + 1;
            end
            chk(n == int'(TBL[i].exp_n), "R6", $sformatf("nap length row %0d (R7 R8 R10)", i),
                n, int'(TBL[i].exp_n));
            chk(cpu_clk_en && !core_rst, "R8", $sformatf("no stab wait row %0d", i),
                {cpu_clk_en, core_rst}, 2'b10);
            chk(wake_vec == TBL[i].ie && wake_resume == !TBL[i].ie, "R9",
                $sformatf("wake kind row %0d", i), {wake_vec, wake_resume}, {TBL[i].ie, !TBL[i].ie});
            @(negedge clk);
            chk(!wake_vec && !wake_resume, "R9", $sformatf("pulse width row %0d", i),
                {wake_vec, wake_resume}, 0);
        end

        // R3 deep stop entry
        wkt_en = 1'b0;
        tmr_sel = 2'd3;
        tmr_period = 8'd0;
        sleep_req = 1'b1;
        @(posedge clk); @(negedge clk);
        sleep_req = 1'b0;
        chk(!osc_en && !cpu_clk_en, "R3", "deep stop outputs", {osc_en, cpu_clk_en}, 2'b00);
        // R4 ext_irq and timer ignored
        ext_irq = 1'b1;
        @(posedge clk); @(negedge clk);
        ext_irq = 1'b0;
        repeat (3000) @(negedge clk);
        chk(!osc_en && !cpu_clk_en && !wake_vec && !wake_resume, "R4", "still stopped",
            {osc_en, cpu_clk_en, wake_vec, wake_resume}, 0);
        // R12 reset out of deep stop
        rst_n = 1'b0;
        #1;
        chk(osc_en && core_rst, "R12", "reset restarts oscillator", {osc_en, core_rst}, 2'b11);
        stab_check("R12");

        // R12 reset during nap
        wkt_en = 1'b1;
        sleep_req = 1'b1;
        @(posedge clk); @(negedge clk);
        sleep_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(core_rst && !cpu_clk_en, "R12", "reset in nap holds core", {core_rst, cpu_clk_en}, 2'b10);
        stab_check("R12");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule